// File: doc/BRIEF.md
# Re-encoding Channel Error Rate Monitor

This block estimates the bit error rate of the hard-decision channel ahead of a convolutional decoder, without needing a known test pattern. The decoder's output bits are fed back through a local copy of the rate-1/2, constraint-length-7 encoder (generators 171 and 133 octal). The block then applies the puncturing of the selected code rate and compares each surviving coded bit with the received bit that produced it. Each mismatch counts as one channel error.

Received symbols enter as depunctured X/Y pairs on the same `step` strobe as the decoded bits, and are held in a delay line whose depth `DELAY` matches the decoder latency. A measurement period is programmed in units of four compared bits. When a period closes, the error tally is copied into a result register that software may read freely, and a sticky interrupt flag is raised. The flag is only visible on `irq` while interrupts are enabled, and it is cleared by a write-one strobe.

Top module: `reencode_ber_monitor`

## Requirements
- R1: After synchronous reset `err_result` is 0, `irq` is low, the encoder history is all zero and the puncture phase is 0.
- R2: On each cycle with `step` high the decoded bit is encoded with taps 171 (X) and 133 (Y) octal over the bit and its six predecessors, and each kept coded bit is compared with the `rx_x`/`rx_y` value presented exactly `DELAY` steps earlier; every mismatch adds one error, and cycles with `step` low change nothing.
- R3: `cfg_rate` selects puncturing: 0 = 1/2 (X 1, Y 1), 1 = 2/3 (X 10, Y 11), 2 = 3/4 (X 101, Y 110), 3 = 5/6 (X 10101, Y 11010), 4 = 6/7 (X 100101, Y 111010), 5 = 7/8 (X 1000101, Y 1111010), with patterns listed by phase from left to right, and codes 6 and 7 behave as 1/2; punctured positions are neither counted nor compared, X is processed before Y within a step, and the phase restarts at 0 when the rate code changes.
- R4: During the first `DELAY` steps after reset no comparison is made, so the empty delay line contributes no errors.
- R5: A period closes on the compared bit that brings the bit count to 4 × `cfg_period`; the error total including that bit is loaded into `err_result`, and both counters restart from zero so that the next bit of the same step belongs to the new period.
- R6: While `cfg_period` is 0 the counters are held at zero, no period closes and `err_result` keeps its value.
- R7: The error tally saturates at its all-ones value instead of wrapping.
- R8: `err_result` changes only when a period closes; observing it has no effect on it.
- R9: A period close sets a sticky flag; `irq` shows the flag only while `cfg_irq_en` is high, so a close with the enable low leaves `irq` low until the enable is raised.
- R10: `irq_clear` high clears the flag at the next edge, but a period close on that same edge wins and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rate | input | 3 | Code-rate selector (R3 encoding) |
| cfg_period | input | PER_W | Period length in units of four compared bits |
| cfg_irq_en | input | 1 | Interrupt enable |
| irq_clear | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| step | input | 1 | One decoded bit and one received pair are valid |
| dec_bit | input | 1 | Decoder output bit |
| rx_x | input | 1 | Received hard-decision bit at the X position |
| rx_y | input | 1 | Received hard-decision bit at the Y position |
| err_result | output | ERR_W | Error count of the last closed period |
| irq | output | 1 | Interrupt request |

## Verification
The bench feeds a random decoded stream and builds channel pairs from its own encoder, flipping X and Y positions at random rates. Flips that land on punctured positions separate correct puncturing from blanket comparison. Every rate code is used, including an unused code and an error-free stream, and idle cycles are mixed in so that only `step` advances state. The first period after reset exposes any comparison against the empty delay line. A second instance driven with an all-wrong channel and a narrow tally separates saturation from wrap-around. Directed sequences separate enable masking, pending-flag reveal, clearing and the close-versus-clear priority.

// File: rtl/ber_mon_pkg.sv
`timescale 1ns/1ps
package ber_mon_pkg;

    typedef enum logic [2:0] {
        RATE_1_2 = 3'd0,
        RATE_2_3 = 3'd1,
        RATE_3_4 = 3'd2,
        RATE_5_6 = 3'd3,
        RATE_6_7 = 3'd4,
        RATE_7_8 = 3'd5
    } rate_e;

    localparam int          PH_W   = 3;
    localparam int          HIST_W = 6;
    localparam logic [6:0]  TAPS_X = 7'o171;
    localparam logic [6:0]  TAPS_Y = 7'o133;

    typedef struct packed {
        logic x;
        logic y;
    } pair_t;

    // number of phases in the puncturing cycle of a rate code
    function automatic logic [PH_W-1:0] cycle_len(input logic [2:0] code);
        case (code)
            RATE_2_3: return 3'd2;
            RATE_3_4: return 3'd3;
            RATE_5_6: return 3'd5;
            RATE_6_7: return 3'd6;
            RATE_7_8: return 3'd7;
            default:  return 3'd1;
        endcase
    endfunction

    // which of the two coded bits survive at a given phase (bit p = phase p)
    function automatic pair_t keep_mask(input logic [2:0] code, input logic [PH_W-1:0] ph);
        logic [6:0] mx;
        logic [6:0] my;
        pair_t      k;
        case (code)
            RATE_2_3: begin mx = 7'b0000001; my = 7'b0000011; end
            RATE_3_4: begin mx = 7'b0000101; my = 7'b0000011; end
            RATE_5_6: begin mx = 7'b0010101; my = 7'b0001011; end
            RATE_6_7: begin mx = 7'b0101001; my = 7'b0010111; end
            RATE_7_8: begin mx = 7'b1010001; my = 7'b0101111; end
            default:  begin mx = 7'b0000001; my = 7'b0000001; end
        endcase
        if (ph < cycle_len(code)) begin
            k.x = mx[ph];
            k.y = my[ph];
        end else begin
            k = '0;
        end
        return k;
    endfunction

    // mother-code output for the current bit and six past bits (hist[5] newest)
    function automatic pair_t conv_out(input logic b, input logic [HIST_W-1:0] hist);
        logic [6:0] v;
        pair_t      o;
        v   = {b, hist};
        o.x = ^(v & TAPS_X);
        o.y = ^(v & TAPS_Y);
        return o;
    endfunction

endpackage

// File: rtl/bm_reencoder.sv
`timescale 1ns/1ps
module bm_reencoder
    import ber_mon_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    input  logic [2:0]  rate,
    input  logic        dec_bit,
    output pair_t       code,
    output pair_t       keep
);

    logic [HIST_W-1:0] hist;
    logic [2:0]        rate_q;
    logic [PH_W-1:0]   phase;
    logic [PH_W-1:0]   phase_inc;

    always_comb begin
        code      = conv_out(dec_bit, hist);
        keep      = keep_mask(rate, phase);
        phase_inc = phase + 3'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist   <= '0;
            rate_q <= RATE_1_2;
            phase  <= '0;
        end else begin
            rate_q <= rate;
            if (step) begin
                hist <= {dec_bit, hist[HIST_W-1:1]};
            end
            if (rate != rate_q) begin
                phase <= '0;
            end else if (step) begin
                phase <= (phase_inc >= cycle_len(rate)) ? '0 : phase_inc;
            end
        end
    end

endmodule

// File: rtl/bm_align_delay.sv
`timescale 1ns/1ps
module bm_align_delay
    import ber_mon_pkg::*;
#(
    parameter int DELAY = 134
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  pair_t din,
    output pair_t dout,
    output logic  warm
);

    localparam int CNT_W = $clog2(DELAY + 1);

    logic [CNT_W-1:0] fill;

    for (genvar i = 0; i < DELAY; i++) begin : g_tap
        pair_t q;
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)       q <= '0;
                else if (step) q <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)       q <= '0;
                else if (step) q <= g_tap[i-1].q;
            end
        end
    end

    assign dout = g_tap[DELAY-1].q;
    assign warm = (fill == CNT_W'(DELAY));

    always_ff @(posedge clk) begin
        if (rst) begin
            fill <= '0;
        end else if (step && !warm) begin
            fill <= fill + 1'b1;
        end
    end

endmodule

// File: rtl/bm_err_accum.sv
`timescale 1ns/1ps
module bm_err_accum
    import ber_mon_pkg::*;
#(
    parameter int ERR_W = 24,
    parameter int PER_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] period,
    input  pair_t            cmp_en,
    input  pair_t            cmp_err,
    output logic             done,
    output logic [ERR_W-1:0] result
);

    localparam int BIT_W = PER_W + 2;

    typedef struct packed {
        logic [BIT_W-1:0] bits;
        logic [ERR_W-1:0] errs;
    } acc_t;

    acc_t             st;
    acc_t             mid;
    acc_t             nxt;
    logic [BIT_W-1:0] target;
    logic [ERR_W-1:0] snap;
    logic             hit_x;
    logic             hit_y;

    // one compared bit: count it, add its error with saturation, flag the close
    function automatic acc_t add_bit(input acc_t s, input logic en, input logic e,
                                     input logic [BIT_W-1:0] tgt, output logic hit);
        acc_t n;
        n   = s;
        hit = 1'b0;
        if (en) begin
            n.bits = s.bits + 1'b1;
            n.errs = (&s.errs) ? s.errs : s.errs + ERR_W'(e);
            hit    = (n.bits >= tgt);
        end
        return n;
    endfunction

    always_comb begin
        target = {period, 2'b00};
        snap   = '0;
        mid    = add_bit(st, cmp_en.x, cmp_err.x, target, hit_x);
        if (hit_x) begin
            snap = mid.errs;
            mid  = '0;
        end
        nxt = add_bit(mid, cmp_en.y, cmp_err.y, target, hit_y);
        if (hit_y) begin
            snap = nxt.errs;
            nxt  = '0;
        end
        done = hit_x | hit_y;
        if (period == '0) begin
            nxt  = '0;
            done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '0;
            result <= '0;
        end else begin
            st <= nxt;
            if (done) begin
                result <= snap;
            end
        end
    end

endmodule

// File: rtl/bm_irq_flag.sv
`timescale 1ns/1ps
module bm_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clear,
    input  logic enable,
    output logic irq
);

    logic flag;

    always_ff @(posedge clk) begin
        if (rst)        flag <= 1'b0;
        else if (set)   flag <= 1'b1;
        else if (clear) flag <= 1'b0;
    end

    assign irq = flag & enable;

endmodule

// File: rtl/reencode_ber_monitor.sv
`timescale 1ns/1ps
module reencode_ber_monitor
    import ber_mon_pkg::*;
#(
    parameter int ERR_W = 24,
    parameter int PER_W = 24,
    parameter int DELAY = 134
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       cfg_rate,
    input  logic [PER_W-1:0] cfg_period,
    input  logic             cfg_irq_en,
    input  logic             irq_clear,
    input  logic             step,
    input  logic             dec_bit,
    input  logic             rx_x,
    input  logic             rx_y,
    output logic [ERR_W-1:0] err_result,
    output logic             irq
);

    pair_t code;
    pair_t keep;
    pair_t rx_in;
    pair_t rx_old;
    pair_t cmp_en;
    pair_t cmp_err;
    logic  warm;
    logic  period_done;

    assign rx_in = '{x: rx_x, y: rx_y};

    bm_reencoder u_enc (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .rate    (cfg_rate),
        .dec_bit (dec_bit),
        .code    (code),
        .keep    (keep)
    );

    bm_align_delay #(.DELAY(DELAY)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .din  (rx_in),
        .dout (rx_old),
        .warm (warm)
    );

    always_comb begin
        cmp_en.x  = keep.x & step & warm;
        cmp_en.y  = keep.y & step & warm;
        cmp_err.x = code.x ^ rx_old.x;
        cmp_err.y = code.y ^ rx_old.y;
    end

    bm_err_accum #(.ERR_W(ERR_W), .PER_W(PER_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .period  (cfg_period),
        .cmp_en  (cmp_en),
        .cmp_err (cmp_err),
        .done    (period_done),
        .result  (err_result)
    );

    bm_irq_flag u_irq (
        .clk    (clk),
        .rst    (rst),
        .set    (period_done),
        .clear  (irq_clear),
        .enable (cfg_irq_en),
        .irq    (irq)
    );

endmodule

// File: rtl/reencode_ber_monitor_chk.sv
`timescale 1ns/1ps
module reencode_ber_monitor_chk #(
    parameter int ERR_W = 24,
    parameter int PER_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic [PER_W-1:0] cfg_period,
    input logic             cfg_irq_en,
    input logic             irq_clear,
    input logic             step,
    input logic [ERR_W-1:0] err_result,
    input logic             irq
);

    // R8: without a step no period can close, so the result holds
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(err_result));

    // R6: a zero period never loads a new result
    assert_idle_period_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_period == '0) |=> $stable(err_result));

    // R9: a new result with interrupts enabled comes with the request
    assert_irq_on_load_R9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(err_result) && cfg_irq_en) |-> irq);

    // R9: the request appears only after a step or when the enable rises
    assert_irq_source_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(step) || $rose(cfg_irq_en)));

    // R10: a clear with no step cannot collide with a close
    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_clear && !step) |=> !irq);

endmodule

bind reencode_ber_monitor reencode_ber_monitor_chk #(.ERR_W(ERR_W), .PER_W(PER_W)) u_chk (.*);

// File: tb/reencode_ber_monitor_test.sv
`timescale 1ns/1ps
module reencode_ber_monitor_test;

    localparam int D    = 134;
    localparam int SD   = 3;
    localparam int NMAX = 4096;
    localparam longint MAXE = 64'hFFFFFF;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  cfg_rate;
    logic [23:0] cfg_period;
    logic        cfg_irq_en;
    logic        mon_clr;
    logic        dir_clr;
    logic        irq_clear;
    logic        step;
    logic        dec_bit;
    logic        rx_x;
    logic        rx_y;
    logic [23:0] err_result;
    logic        irq;
    logic        sat_rx_x;
    logic        sat_rx_y;
    logic [3:0]  sat_result;
    logic        sat_irq;

    always #4 clk = ~clk;
    assign irq_clear = mon_clr | dir_clr;

    reencode_ber_monitor uut (
        .clk(clk), .rst(rst), .cfg_rate(cfg_rate), .cfg_period(cfg_period),
        .cfg_irq_en(cfg_irq_en), .irq_clear(irq_clear), .step(step),
        .dec_bit(dec_bit), .rx_x(rx_x), .rx_y(rx_y),
        .err_result(err_result), .irq(irq)
    );

    reencode_ber_monitor #(.ERR_W(4), .PER_W(8), .DELAY(SD)) uut_sat (
        .clk(clk), .rst(rst), .cfg_rate(cfg_rate), .cfg_period(8'd8),
        .cfg_irq_en(1'b0), .irq_clear(1'b0), .step(step),
        .dec_bit(dec_bit), .rx_x(sat_rx_x), .rx_y(sat_rx_y),
        .err_result(sat_result), .irq(sat_irq)
    );

    int     tests = 0;
    int     fails = 0;
    bit     mon_on = 1'b0;
    bit     dseq  [NMAX];
    bit     encx  [NMAX];
    bit     ency  [NMAX];
    bit     flx   [NMAX];
    bit     fly   [NMAX];
    int     s  = 0;
    int     ph = 0;
    int     rate_m = 0;
    longint mbits = 0;
    longint merrs = 0;
    longint last_exp = 0;
    longint expq [$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // puncture tables written left to right by phase
    function automatic int plen(input int r);
        case (r)
            1: return 2;
            2: return 3;
            3: return 5;
            4: return 6;
            5: return 7;
            default: return 1;
        endcase
    endfunction

    function automatic bit kx(input int r, input int p);
        logic [6:0] v;
        case (r)
            1: v = 7'b10;
            2: v = 7'b101;
            3: v = 7'b10101;
            4: v = 7'b100101;
            5: v = 7'b1000101;
            default: v = 7'b1;
        endcase
        return v[plen(r)-1-p];
    endfunction

    function automatic bit ky(input int r, input int p);
        logic [6:0] v;
        case (r)
            1: v = 7'b11;
            2: v = 7'b110;
            3: v = 7'b11010;
            4: v = 7'b111010;
            5: v = 7'b1111010;
            default: v = 7'b1;
        endcase
        return v[plen(r)-1-p];
    endfunction

    function automatic bit hb(input int i, input int k);
        return (i >= k) ? dseq[i-k] : 1'b0;
    endfunction

    task automatic count_bit(input bit e, inout bit hit);
        mbits++;
        merrs = (merrs == MAXE) ? merrs : merrs + longint'(e);
        if (mbits >= 4 * longint'(cfg_period)) begin
            expq.push_back(merrs);
            last_exp = merrs;
            mbits = 0;
            merrs = 0;
            hit = 1'b1;
        end
    endtask

    task automatic drive_step(input int pct, inout bit hit);
        int idx;
        idx = s + D;
        flx[idx] = ($urandom_range(99) < pct);
        fly[idx] = ($urandom_range(99) < pct);
        step     = 1'b1;
        dec_bit  = dseq[s];
        rx_x     = encx[idx] ^ flx[idx];
        rx_y     = ency[idx] ^ fly[idx];
        sat_rx_x = ~encx[s+SD];
        sat_rx_y = ~ency[s+SD];
        if (cfg_period == 0) begin
            mbits = 0;
            merrs = 0;
        end else if (s >= D) begin
            if (kx(rate_m, ph)) count_bit(flx[s], hit);
            if (ky(rate_m, ph)) count_bit(fly[s], hit);
        end
        ph = (ph + 1) % plen(rate_m);
        s++;
    endtask

    task automatic run(input int n, input int pct, input bit gaps, input bit stop_on_done);
        bit hit;
        hit = 1'b0;
        for (int i = 0; i < n && !(stop_on_done && hit); i++) begin
            @(negedge clk);
            if (gaps && $urandom_range(3) == 0) begin
                step = 1'b0;
                @(negedge clk);
            end
            drive_step(pct, hit);
        end
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic set_rate(input int r);
        @(negedge clk);
        step     = 1'b0;
        cfg_rate = 3'(r);
        rate_m   = (r > 5) ? 0 : r;
        ph       = 0;
    endtask

    // scoreboard monitor: each visible request pops one expected snapshot
    initial begin
        mon_clr = 1'b0;
        forever begin
            @(negedge clk);
            if (mon_on && irq) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R9 request with no expected period", 1, 0);
                end else begin
                    longint e;
                    e = expq.pop_front();
                    // R2 R3 R4 R5: snapshot of the closed period
                    chk(err_result == 24'(e), "R2/R3/R4/R5 period snapshot",
                        longint'(err_result), e);
                end
                mon_clr = 1'b1;
            end else begin
                mon_clr = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [23:0] held;
        for (int i = 0; i < NMAX; i++) begin
            dseq[i] = 1'($urandom_range(1));
            encx[i] = dseq[i] ^ hb(i, 1) ^ hb(i, 2) ^ hb(i, 3) ^ hb(i, 6);
            ency[i] = dseq[i] ^ hb(i, 2) ^ hb(i, 3) ^ hb(i, 5) ^ hb(i, 6);
            flx[i]  = 1'b0;
            fly[i]  = 1'b0;
        end
        rst = 1'b1; step = 1'b0; dec_bit = 1'b0; rx_x = 1'b0; rx_y = 1'b0;
        sat_rx_x = 1'b0; sat_rx_y = 1'b0; dir_clr = 1'b0;
        cfg_rate = 3'd0; cfg_period = 24'd16; cfg_irq_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(err_result == 0, "R1 reset result", longint'(err_result), 0);
        chk(irq == 1'b0, "R1 reset irq", longint'(irq), 0);

        cfg_irq_en = 1'b1;
        mon_on = 1'b1;
        // R2 R4: rate 1/2, first period spans the warm-up
        set_rate(0); cfg_period = 24'd16;
        run(300, 5, 1'b1, 1'b0);
        // R3: every punctured rate, flips also hit punctured positions
        for (int r = 1; r <= 5; r++) begin
            set_rate(r); cfg_period = 24'd10;
            run(200, 20, 1'b1, 1'b0);
        end
        // R3: unused code 6 acts as 1/2
        set_rate(6); cfg_period = 24'd10;
        run(60, 10, 1'b0, 1'b0);
        // R2: error-free stream gives zero counts
        set_rate(2); cfg_period = 24'd8;
        run(100, 0, 1'b0, 1'b0);
        repeat (6) @(negedge clk);
        chk(expq.size() == 0, "R5 every closed period reported", expq.size(), 0);

        // R8: result holds while only observed
        held = err_result;
        repeat (20) @(negedge clk);
        chk(err_result == held, "R8 result not cleared by reading", longint'(err_result), longint'(held));
        chk(err_result == 24'(last_exp), "R8 result is last period", longint'(err_result), last_exp);

        // R6: zero period
        cfg_period = 24'd0;
        run(60, 30, 1'b0, 1'b0);
        @(negedge clk);
        chk(err_result == held, "R6 zero period keeps result", longint'(err_result), longint'(held));
        chk(irq == 1'b0, "R6 zero period no request", longint'(irq), 0);

        // R9: gated close, pending flag shown once enabled
        mon_on = 1'b0;
        @(negedge clk);
        cfg_irq_en = 1'b0;
        set_rate(0); cfg_period = 24'd4;
        run(200, 30, 1'b0, 1'b1);
        chk(irq == 1'b0, "R9 disabled request stays low", longint'(irq), 0);
        chk(err_result == 24'(last_exp), "R5 gated period snapshot", longint'(err_result), last_exp);
        cfg_irq_en = 1'b1;
        @(negedge clk);
        chk(irq == 1'b1, "R9 pending flag shown on enable", longint'(irq), 1);
        dir_clr = 1'b1;
        @(negedge clk);
        dir_clr = 1'b0;
        chk(irq == 1'b0, "R10 clear drops request", longint'(irq), 0);

        // R10: close on the same edge as a clear wins
        dir_clr = 1'b1;
        run(200, 30, 1'b0, 1'b1);
        dir_clr = 1'b0;
        chk(irq == 1'b1, "R10 close beats clear", longint'(irq), 1);
        chk(err_result == 24'(last_exp), "R5 snapshot at collision", longint'(err_result), last_exp);
        dir_clr = 1'b1;
        @(negedge clk);
        dir_clr = 1'b0;
        chk(irq == 1'b0, "R10 later clear drops request", longint'(irq), 0);

        // R7: all-wrong channel into a 4-bit tally with 32-bit periods
        chk(sat_result == 4'hF, "R7 tally saturates", longint'(sat_result), 15);
        chk(sat_irq == 1'b0, "R9 disabled instance never requests", longint'(sat_irq), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule